// File: doc/BRIEF.md
# Dual Wiper Code Register Controller with Serial Write Port

This block takes a write-only three-wire serial stream (active-low select, serial clock, serial data) and keeps two 8-bit wiper codes for a dual digital potentiometer. While the select line is low, each rising edge of the serial clock shifts one data bit into a 9-bit input word. When the select line goes high again, the most recent 9 bits are split into a channel address and a code. The addressed wiper code is then replaced, and a one-cycle update strobe is raised for that channel.

All three serial lines pass through two-flop synchronizers into the system clock domain, and their edges are detected there. As a result, the system clock must run at least four times faster than the serial clock. Both wiper codes are driven out in parallel. For each channel the block also drives the ideal wiper-to-B and wiper-to-A resistances in ohms, computed from the code, the end-to-end resistance and the wiper contact resistance.

Top module: `dualwiper_spi_ctrl`

## Requirements
- R1: A frame is shifted in most significant bit first. In the last 9 bits received, bit 8 is the channel address (0 writes channel 0, 1 writes channel 1) and bits 7..0 are the new code.
- R2: Data is sampled only on rising serial clock edges seen while the select line is low. Clock edges while the select line is high shift nothing.
- R3: A wiper code changes only in response to a rising edge of the select line. The new value appears on the third system clock edge after the select line goes high, and never earlier.
- R4: When a frame has more than 9 rising clock edges, only the last 9 bits received are used.
- R5: When a frame has fewer than 9 rising clock edges, it is dropped, and neither code nor strobe changes.
- R6: After reset both wiper codes are 0x80 (midscale) and both strobes are low.
- R7: The channel that is not addressed keeps its code through every write.
- R8: Each accepted frame raises the strobe of the addressed channel for exactly one cycle, in the same cycle the new code appears. The other strobe stays low.
- R9: For a code D, the wiper-to-B output is floor(D×R_AB/256)+2×R_W and the wiper-to-A output is floor((256−D)×R_AB/256)+2×R_W. With the defaults R_AB=10000 and R_W=50, code 0x00 gives 100 and 10100, and code 0xFF gives 10060 and 139.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Serial select, active low; its rising edge ends a frame |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| wiper_o | output | 2×CODE_W | Wiper codes; channel g is at [g*CODE_W +: CODE_W] |
| upd_o | output | 2 | One-cycle update strobe per channel |
| res_wb_o | output | 2×RES_W | Wiper-to-B resistance in ohms per channel |
| res_wa_o | output | 2×RES_W | Wiper-to-A resistance in ohms per channel |

## Verification
The assertions assume that the serial lines change away from the system clock edge and that the serial clock stays in each level for at least two system cycles. This lets every select and clock edge be seen once after synchronization. The assertions also assume that reset is asserted at time zero. The bench drives every serial line on the falling system clock edge and holds each serial clock level for four system cycles. It raises the select line only after the last serial clock fall has settled. Under these conditions, a strobe implies that the select line was high three cycles earlier, and the two resistance outputs of each channel always sum to R_AB+4×R_W, or one less because of truncation.

// File: rtl/dualwiper_pkg.sv
package dualwiper_pkg;

  // Ideal tap resistance in ohms: floor(taps * rab / steps) + 2 * rw
  function automatic logic [31:0] tap_res(input logic [31:0] taps,
                                          input logic [31:0] rab,
                                          input logic [31:0] rw,
                                          input logic [31:0] steps);
    return ((taps * rab) / steps) + (rw << 1);
  endfunction

endpackage

// File: rtl/dualwiper_sync.sv
module dualwiper_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/dualwiper_frame.sv
module dualwiper_frame #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              commit_o,
  output logic              addr_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned WORD_W = CODE_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic              cs_prev_q, sclk_prev_q;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cs_rise, sclk_rise, shift_en, cnt_full;

  assign cs_rise   = cs_n_s & ~cs_prev_q;
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign shift_en  = sclk_rise & ~cs_n_s;
  assign cnt_full  = (cnt_q == CNT_W'(WORD_W));

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (cs_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      shift_d = {shift_q[WORD_W-2:0], sdi_s};
      if (!cnt_full) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
      cnt_q       <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  assign commit_o = cs_rise & cnt_full;
  assign addr_o   = shift_q[WORD_W-1];
  assign code_o   = shift_q[CODE_W-1:0];
endmodule

// File: rtl/dualwiper_bank.sv
module dualwiper_bank
  import dualwiper_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned RES_W    = 24,
  parameter int unsigned RAB_OHMS = 10000,
  parameter int unsigned RW_OHMS  = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_i,
  input  logic                addr_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic [2*CODE_W-1:0] wiper_o,
  output logic [1:0]          upd_o,
  output logic [2*RES_W-1:0]  res_wb_o,
  output logic [2*RES_W-1:0]  res_wa_o
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned STEPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic              upd_q;
    logic              wr_en;
    logic [31:0]       wb_full, wa_full;

    assign wr_en = commit_i & (addr_i == 1'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= MID_CODE;
      else if (wr_en) code_q <= code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q <= 1'b0;
      else upd_q <= wr_en;
    end

    assign wb_full = tap_res(32'(code_q), 32'(RAB_OHMS), 32'(RW_OHMS), 32'(STEPS));
    assign wa_full = tap_res(32'(STEPS) - 32'(code_q), 32'(RAB_OHMS), 32'(RW_OHMS),
                             32'(STEPS));

    assign wiper_o[g*CODE_W +: CODE_W] = code_q;
    assign upd_o[g]                    = upd_q;
    assign res_wb_o[g*RES_W +: RES_W]  = wb_full[RES_W-1:0];
    assign res_wa_o[g*RES_W +: RES_W]  = wa_full[RES_W-1:0];
  end
endmodule

// File: rtl/dualwiper_spi_ctrl.sv
module dualwiper_spi_ctrl #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned RES_W    = 24,
  parameter int unsigned RAB_OHMS = 10000,
  parameter int unsigned RW_OHMS  = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  output logic [2*CODE_W-1:0] wiper_o,
  output logic [1:0]          upd_o,
  output logic [2*RES_W-1:0]  res_wb_o,
  output logic [2*RES_W-1:0]  res_wa_o
);
  logic              rst_meta_q, rst_int_n;
  logic [2:0]        line_s;
  logic              commit;
  logic              addr;
  logic [CODE_W-1:0] code;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // bit 2: select (idles high), bit 1: serial clock, bit 0: data
  dualwiper_sync #(.WIDTH(3), .RST_VAL(3'b100)) sync_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({cs_n, sclk, sdi}),
    .sync_o  (line_s)
  );

  dualwiper_frame #(.CODE_W(CODE_W)) frame_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n_s   (line_s[2]),
    .sclk_s   (line_s[1]),
    .sdi_s    (line_s[0]),
    .commit_o (commit),
    .addr_o   (addr),
    .code_o   (code)
  );

  dualwiper_bank #(
    .CODE_W(CODE_W), .RES_W(RES_W), .RAB_OHMS(RAB_OHMS), .RW_OHMS(RW_OHMS)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .commit_i (commit),
    .addr_i   (addr),
    .code_i   (code),
    .wiper_o  (wiper_o),
    .upd_o    (upd_o),
    .res_wb_o (res_wb_o),
    .res_wa_o (res_wa_o)
  );
endmodule

// File: rtl/dualwiper_chk.sv
module dualwiper_chk #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned RES_W    = 24,
  parameter int unsigned RAB_OHMS = 10000,
  parameter int unsigned RW_OHMS  = 50
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic [2*CODE_W-1:0] wiper_o,
  input logic [1:0]          upd_o,
  input logic [2*RES_W-1:0]  res_wb_o,
  input logic [2*RES_W-1:0]  res_wa_o
);
  localparam logic [31:0] SUM_HI = 32'(RAB_OHMS) + 32'(4 * RW_OHMS);

  logic [31:0] sum0, sum1;
  assign sum0 = 32'(res_wb_o[RES_W-1:0])       + 32'(res_wa_o[RES_W-1:0]);
  assign sum1 = 32'(res_wb_o[2*RES_W-1:RES_W]) + 32'(res_wa_o[2*RES_W-1:RES_W]);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_o));

  a_r8_pulse_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o[0] |=> !upd_o[0]);

  a_r8_pulse_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o[1] |=> !upd_o[1]);

  a_r7_hold_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o[0] |-> $stable(wiper_o[CODE_W-1:0]));

  a_r7_hold_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o[1] |-> $stable(wiper_o[2*CODE_W-1:CODE_W]));

  a_r3_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o != 2'b00) |-> ($past(cs_n, 3) && $past(cs_n, 1)));

  a_r9_sum_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (sum0 == SUM_HI) || (sum0 == SUM_HI - 32'd1));

  a_r9_sum_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (sum1 == SUM_HI) || (sum1 == SUM_HI - 32'd1));
endmodule

bind dualwiper_spi_ctrl dualwiper_chk #(
  .CODE_W(CODE_W), .RES_W(RES_W), .RAB_OHMS(RAB_OHMS), .RW_OHMS(RW_OHMS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .wiper_o  (wiper_o),
  .upd_o    (upd_o),
  .res_wb_o (res_wb_o),
  .res_wa_o (res_wa_o)
);

// File: tb/dualwiper_spi_ctrl_tb_top.sv
`timescale 1ns/1ps
module dualwiper_spi_ctrl_tb_top;
  localparam int CODE_W = 8;
  localparam int RES_W  = 24;
  localparam int RAB    = 10000;
  localparam int RW     = 50;
  localparam int HALF   = 4;   // system cycles per serial clock level

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [2*CODE_W-1:0] wiper_o;
  logic [1:0]          upd_o;
  logic [2*RES_W-1:0]  res_wb_o, res_wa_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_code [2];

  always #5 clk = ~clk;

  dualwiper_spi_ctrl #(.CODE_W(CODE_W), .RES_W(RES_W), .RAB_OHMS(RAB), .RW_OHMS(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .wiper_o(wiper_o), .upd_o(upd_o), .res_wb_o(res_wb_o), .res_wa_o(res_wa_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wb_of(input int d);
    return 32'((d * RAB) / 256 + 2 * RW);
  endfunction
  function automatic logic [31:0] wa_of(input int d);
    return 32'(((256 - d) * RAB) / 256 + 2 * RW);
  endfunction

  task automatic check_all(input string req);
    for (int g = 0; g < 2; g++) begin
      chk(req, 32'(wiper_o[g*CODE_W +: CODE_W]), 32'(exp_code[g]));
      chk({req, "/R9 wb"}, 32'(res_wb_o[g*RES_W +: RES_W]), wb_of(int'(exp_code[g])));
      chk({req, "/R9 wa"}, 32'(res_wa_o[g*RES_W +: RES_W]), wa_of(int'(exp_code[g])));
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Observe the release of the select line, driven at a falling edge.
  task automatic observe_end(input bit accept, input logic a, input logic [7:0] c);
    logic [7:0] old [2];
    old = exp_code;
    cs_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k < 3) begin
        chk("R3 no early change ch0", 32'(wiper_o[7:0]), 32'(old[0]));
        chk("R3 no early change ch1", 32'(wiper_o[15:8]), 32'(old[1]));
        chk("R3 no early strobe", 32'(upd_o), 32'd0);
      end else if (k == 3) begin
        if (accept) exp_code[a] = c;
        check_all("R1/R3/R7 code after commit");
        chk("R8 strobe at commit", 32'(upd_o), accept ? (a ? 32'd2 : 32'd1) : 32'd0);
      end else begin
        chk("R8 strobe one cycle", 32'(upd_o), 32'd0);
        check_all("R7 held");
      end
    end
  endtask

  task automatic send(input int nbits, input logic [15:0] word);
    cs_n = 1'b0;
    wait_n(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = word[i];
      wait_n(HALF);
      sclk = 1'b1;
      wait_n(HALF);
      sclk = 1'b0;
    end
    wait_n(HALF);
    observe_end(nbits >= 9, word[8], word[7:0]);
    wait_n(2);
  endtask

  initial begin
    exp_code[0] = 8'h80;
    exp_code[1] = 8'h80;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    check_all("R6 reset midscale");
    chk("R6 reset strobe", 32'(upd_o), 32'd0);
    chk("R9 midscale wb", 32'(res_wb_o[RES_W-1:0]), 32'd5100);

    // R1/R9/R7 exhaustive sweep over both channels and all codes
    for (int ch = 0; ch < 2; ch++)
      for (int d = 0; d < 256; d++)
        send(9, 16'({ch[0], d[7:0]}));

    // R9 corner values with defaults
    send(9, 16'h000);
    chk("R9 zero scale wb", 32'(res_wb_o[RES_W-1:0]), 32'd100);
    chk("R9 zero scale wa", 32'(res_wa_o[RES_W-1:0]), 32'd10100);
    send(9, 16'h1FF);
    chk("R9 full scale wb", 32'(res_wb_o[2*RES_W-1:RES_W]), 32'd10060);
    chk("R9 full scale wa", 32'(res_wa_o[2*RES_W-1:RES_W]), 32'd139);

    // R5 short frames: 8 bits and none
    send(8, 16'h0AA);
    send(0, 16'h000);
    send(1, 16'h001);

    // R4 overlong frames keep the last 9 bits
    send(12, 16'hA5C);   // ch0 <- 0x5C
    send(16, 16'hFF23);  // ch1 <- 0x23
    send(10, 16'h2C3);   // ch0 <- 0xC3

    // R2 clock edges while the select line is high shift nothing
    sdi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wait_n(HALF); sclk = 1'b1; wait_n(HALF); sclk = 1'b0;
    end
    cs_n = 1'b0;
    wait_n(3 * HALF);
    observe_end(1'b0, 1'b0, 8'h00);
    check_all("R2 idle clocks ignored");
    // R2: the following short frame must still be incomplete
    send(8, 16'h0FF);

    // R6 reset again after activity
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(4);
    exp_code[0] = 8'h80;
    exp_code[1] = 8'h80;
    check_all("R6 reset after writes");
    send(9, 16'h111);  // ch1 <- 0x11 after reset

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule